// File: doc/BRIEF.md
# Versioned Register Store for Speculative Thread Units

This block keeps register state for a group of thread units that run speculative threads at the same time. Each unit owns a private copy of the register set. One shared bank holds the committed state. A holder table, with one row per logical register and one bit per unit, records which units currently own a version of each register. A read from a unit returns its own version when it has one. Otherwise it returns the version of the nearest older thread that owns the register. When no older thread owns it, the read returns the committed copy. The age of each thread comes in as a rank vector: rank 0 is the non-speculative thread and higher ranks are younger.

A spawn copies a chosen set of registers from a parent unit into a child unit. While a speculative thread runs, the block logs each externally sourced value it consumes. This includes values that its pre-computation slice produced. A validate request later walks the log one register per cycle and compares each entry with the value the thread's predecessor now holds. A commit request walks the register set one register per cycle and copies the unit's modified registers into the committed bank. Each sequence ends with a one-cycle done pulse. A squash erases a unit's versions and its log.

Top module: `mvrf_top`

## Requirements
- R1: After reset, no unit holds any register and the committed bank is all zero, so every read port returns 0. `busy`, `done` and `mismatch` are low.
- R2: A write from a unit updates that unit's own version, and that unit's later reads of the register return it.
- R3: When a unit does not hold a register, its read returns the version of the holding unit with the largest rank below its own. When no unit of smaller rank holds the register, the read returns the committed copy. Units of equal or larger rank are never used.
- R4: A spawn first clears every register the child held. It then copies into the child each register whose `spawn_mask` bit (bit n for register n) is set and which the parent holds. Registers outside the mask are not copied.
- R5: A read logs the returned value only when all of these hold: the reading unit has a non-zero rank, is not in its slice, has not written the register outside its slice since it was spawned, and has not yet logged that register. Later reads never overwrite a logged value.
- R6: A validate request compares every logged entry of the named unit with the value that R3 lookup gives that unit, excluding its own version. `mismatch` is high during the `done` pulse exactly when at least one entry differs.
- R7: A register written during the slice and never read by the thread afterwards is not compared at validation.
- R8: A squash clears the unit's column of the holder table and its log. The unit's later reads resolve through predecessors or the committed bank.
- R9: A commit copies every register the unit modified into the committed bank. It leaves the other registers unchanged and then clears the unit's column.
- R10: A validate or commit request accepted at a clock edge raises `busy` from that edge on. It pulses `done` for one cycle after exactly NUM_REGS further edges, scanning one register per edge. Validate wins when both requests arrive together.
- R11: A validate or commit request that arrives while a sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thread_rank | input | NUM_UNITS*UW | Age rank per unit, 0 = non-speculative |
| in_slice | input | NUM_UNITS | Unit is executing its pre-computation slice |
| rd_en | input | NUM_UNITS | Read consumed by the thread (enables logging) |
| rd_addr | input | NUM_UNITS*AW | Read register index per unit |
| rd_data | output | NUM_UNITS*DATA_W | Resolved read value per unit |
| wr_en | input | NUM_UNITS | Write strobe per unit |
| wr_addr | input | NUM_UNITS*AW | Write register index per unit |
| wr_data | input | NUM_UNITS*DATA_W | Write value per unit |
| spawn_req | input | 1 | Spawn strobe |
| spawn_parent | input | UW | Parent unit |
| spawn_child | input | UW | Child unit |
| spawn_mask | input | NUM_REGS | Registers to copy, bit n = register n |
| squash_req | input | 1 | Squash strobe |
| squash_unit | input | UW | Unit to squash |
| val_req | input | 1 | Validate request |
| val_unit | input | UW | Unit to validate |
| commit_req | input | 1 | Commit request |
| commit_unit | input | UW | Unit to commit |
| busy | output | 1 | Scan sequence running |
| done | output | 1 | One-cycle end-of-sequence pulse |
| mismatch | output | 1 | Validation failed, valid with done |

## Verification
The checker assumes that `thread_rank` is a permutation of the unit numbers. It also assumes that a squash and a spawn naming the same unit never arrive in the same cycle, and that writes and requests that affect a scanned unit stay quiet while a sequence runs. The bench drives one operation per cycle, sets ranks explicitly before each scenario, and only overlaps a request with a running scan in the scenario built to show that the request is ignored.

// File: rtl/mvrf_pkg.sv
package mvrf_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_VSCAN,
        S_CSCAN,
        S_DONE
    } seq_state_t;
endpackage

// File: rtl/mvrf_pred_select.sv
module mvrf_pred_select #(
    parameter int NU = 4,
    parameter int UW = 2
) (
    input  logic [NU-1:0]    holders,
    input  logic [NU*UW-1:0] ranks,
    input  logic [UW-1:0]    self_rank,
    output logic             found,
    output logic [UW-1:0]    sel
);
    logic [UW-1:0] best;

    always_comb begin
        found = 1'b0;
        sel   = '0;
        best  = '0;
        for (int j = 0; j < NU; j++) begin
            if (holders[j] && (ranks[j*UW +: UW] < self_rank) &&
                (!found || (ranks[j*UW +: UW] > best))) begin
                found = 1'b1;
                sel   = UW'(j);
                best  = ranks[j*UW +: UW];
            end
        end
    end
endmodule

// File: rtl/mvrf_vstore.sv
module mvrf_vstore #(
    parameter int NU = 4,
    parameter int NR = 16,
    parameter int DW = 32,
    parameter int AW = 4,
    parameter int UW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NU-1:0]    cap_en,
    input  logic [NU*AW-1:0] cap_addr,
    input  logic [NU*DW-1:0] cap_data,
    input  logic [NU-1:0]    clr,
    input  logic [UW-1:0]    q_unit,
    input  logic [AW-1:0]    q_idx,
    output logic             q_logged,
    output logic [DW-1:0]    q_value
);
    logic [NU-1:0][NR-1:0]         logged_q;
    logic [NU-1:0][NR-1:0][DW-1:0] value_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            logged_q <= '0;
            value_q  <= '0;
        end else begin
            for (int u = 0; u < NU; u++) begin
                if (clr[u]) begin
                    logged_q[u] <= '0;
                end else if (cap_en[u] && !logged_q[u][cap_addr[u*AW +: AW]]) begin
                    logged_q[u][cap_addr[u*AW +: AW]] <= 1'b1;
                    value_q[u][cap_addr[u*AW +: AW]]  <= cap_data[u*DW +: DW];
                end
            end
        end
    end

    assign q_logged = logged_q[q_unit][q_idx];
    assign q_value  = value_q[q_unit][q_idx];
endmodule

// File: rtl/mvrf_seq_ctrl.sv
module mvrf_seq_ctrl
    import mvrf_pkg::*;
#(
    parameter int NR = 16,
    parameter int AW = 4,
    parameter int UW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          val_req,
    input  logic [UW-1:0] val_unit,
    input  logic          commit_req,
    input  logic [UW-1:0] commit_unit,
    input  logic          cmp_fail,
    output logic          busy,
    output logic          done,
    output logic          mismatch,
    output logic [AW-1:0] scan_idx,
    output logic [UW-1:0] scan_unit,
    output logic          scan_val,
    output logic          scan_commit,
    output logic          commit_end
);
    seq_state_t    state_q, state_d;
    logic [AW-1:0] idx_q;
    logic [UW-1:0] unit_q;
    logic          fail_q;
    logic          last;

    assign last = (idx_q == AW'(NR - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (val_req)         state_d = S_VSCAN;
                else if (commit_req) state_d = S_CSCAN;
            end
            S_VSCAN: if (last) state_d = S_DONE;
            S_CSCAN: if (last) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // scan datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            unit_q <= '0;
            fail_q <= 1'b0;
        end else if (state_q == S_IDLE) begin
            idx_q  <= '0;
            fail_q <= 1'b0;
            if (val_req)         unit_q <= val_unit;
            else if (commit_req) unit_q <= commit_unit;
        end else if (state_q == S_VSCAN || state_q == S_CSCAN) begin
            idx_q <= idx_q + 1'b1;
            if (state_q == S_VSCAN && cmp_fail) fail_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy        = (state_q == S_VSCAN) || (state_q == S_CSCAN);
        done        = (state_q == S_DONE);
        mismatch    = (state_q == S_DONE) && fail_q;
        scan_val    = (state_q == S_VSCAN);
        scan_commit = (state_q == S_CSCAN);
        commit_end  = (state_q == S_CSCAN) && last;
        scan_idx    = idx_q;
        scan_unit   = unit_q;
    end
endmodule

// File: rtl/mvrf_top.sv
module mvrf_top #(
    parameter int NUM_UNITS = 4,
    parameter int NUM_REGS  = 16,
    parameter int DATA_W    = 32,
    localparam int UW = $clog2(NUM_UNITS),
    localparam int AW = $clog2(NUM_REGS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_UNITS*UW-1:0]     thread_rank,
    input  logic [NUM_UNITS-1:0]        in_slice,
    input  logic [NUM_UNITS-1:0]        rd_en,
    input  logic [NUM_UNITS*AW-1:0]     rd_addr,
    output logic [NUM_UNITS*DATA_W-1:0] rd_data,
    input  logic [NUM_UNITS-1:0]        wr_en,
    input  logic [NUM_UNITS*AW-1:0]     wr_addr,
    input  logic [NUM_UNITS*DATA_W-1:0] wr_data,
    input  logic                        spawn_req,
    input  logic [UW-1:0]               spawn_parent,
    input  logic [UW-1:0]               spawn_child,
    input  logic [NUM_REGS-1:0]         spawn_mask,
    input  logic                        squash_req,
    input  logic [UW-1:0]               squash_unit,
    input  logic                        val_req,
    input  logic [UW-1:0]               val_unit,
    input  logic                        commit_req,
    input  logic [UW-1:0]               commit_unit,
    output logic                        busy,
    output logic                        done,
    output logic                        mismatch
);
    localparam int NU = NUM_UNITS;
    localparam int NR = NUM_REGS;
    localparam int DW = DATA_W;

    logic [NU-1:0][NR-1:0][DW-1:0] loc_q;
    logic [NR-1:0][NU-1:0]         vt_q;
    logic [NU-1:0][NR-1:0]         mod_q;
    logic [NU-1:0][NR-1:0]         prod_q;
    logic [NR-1:0][DW-1:0]         glob_q;

    logic [NU-1:0]         cap_en;
    logic [NU-1:0]         clr_vec;
    logic [AW-1:0]         scan_idx;
    logic [UW-1:0]         scan_unit;
    logic                  scan_val, scan_commit, commit_end;
    logic                  cmp_fail;
    logic                  q_logged;
    logic [DW-1:0]         q_value;
    logic                  sc_found;
    logic [UW-1:0]         sc_sel;
    logic [DW-1:0]         sc_value;

    // per-unit read lookup
    for (genvar u = 0; u < NU; u++) begin : g_rd
        logic [AW-1:0] a;
        logic [UW-1:0] rk;
        logic          pf;
        logic [UW-1:0] ps;
        assign a  = rd_addr[u*AW +: AW];
        assign rk = thread_rank[u*UW +: UW];
        mvrf_pred_select #(.NU(NU), .UW(UW)) u_pred (
            .holders  (vt_q[a]),
            .ranks    (thread_rank),
            .self_rank(rk),
            .found    (pf),
            .sel      (ps)
        );
        assign rd_data[u*DW +: DW] = vt_q[a][u] ? loc_q[u][a] :
                                     pf         ? loc_q[ps][a] : glob_q[a];
        assign cap_en[u] = rd_en[u] && (rk != '0) && !in_slice[u] && !prod_q[u][a];
        assign clr_vec[u] = (squash_req && squash_unit == UW'(u)) ||
                            (spawn_req && spawn_child == UW'(u)) ||
                            (commit_end && scan_unit == UW'(u));
    end

    mvrf_vstore #(.NU(NU), .NR(NR), .DW(DW), .AW(AW), .UW(UW)) u_vstore (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .cap_addr(rd_addr),
        .cap_data(rd_data),
        .clr     (clr_vec),
        .q_unit  (scan_unit),
        .q_idx   (scan_idx),
        .q_logged(q_logged),
        .q_value (q_value)
    );

    // predecessor lookup for the validation scan
    mvrf_pred_select #(.NU(NU), .UW(UW)) u_scan_pred (
        .holders  (vt_q[scan_idx]),
        .ranks    (thread_rank),
        .self_rank(thread_rank[scan_unit*UW +: UW]),
        .found    (sc_found),
        .sel      (sc_sel)
    );
    assign sc_value = sc_found ? loc_q[sc_sel][scan_idx] : glob_q[scan_idx];
    assign cmp_fail = scan_val && q_logged && (sc_value != q_value);

    mvrf_seq_ctrl #(.NR(NR), .AW(AW), .UW(UW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .val_req    (val_req),
        .val_unit   (val_unit),
        .commit_req (commit_req),
        .commit_unit(commit_unit),
        .cmp_fail   (cmp_fail),
        .busy       (busy),
        .done       (done),
        .mismatch   (mismatch),
        .scan_idx   (scan_idx),
        .scan_unit  (scan_unit),
        .scan_val   (scan_val),
        .scan_commit(scan_commit),
        .commit_end (commit_end)
    );

    // storage update; later statements take priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_q  <= '0;
            vt_q   <= '0;
            mod_q  <= '0;
            prod_q <= '0;
            glob_q <= '0;
        end else begin
            for (int u = 0; u < NU; u++) begin
                if (wr_en[u]) begin
                    loc_q[u][wr_addr[u*AW +: AW]] <= wr_data[u*DW +: DW];
                    vt_q[wr_addr[u*AW +: AW]][u]  <= 1'b1;
                    mod_q[u][wr_addr[u*AW +: AW]] <= 1'b1;
                    if (!in_slice[u]) prod_q[u][wr_addr[u*AW +: AW]] <= 1'b1;
                end
            end
            if (spawn_req) begin
                for (int r = 0; r < NR; r++) begin
                    vt_q[r][spawn_child]   <= spawn_mask[r] & vt_q[r][spawn_parent];
                    mod_q[spawn_child][r]  <= 1'b0;
                    prod_q[spawn_child][r] <= 1'b0;
                    if (spawn_mask[r] && vt_q[r][spawn_parent])
                        loc_q[spawn_child][r] <= loc_q[spawn_parent][r];
                end
            end
            if (squash_req) begin
                for (int r = 0; r < NR; r++) begin
                    vt_q[r][squash_unit]   <= 1'b0;
                    mod_q[squash_unit][r]  <= 1'b0;
                    prod_q[squash_unit][r] <= 1'b0;
                end
            end
            if (scan_commit && mod_q[scan_unit][scan_idx])
                glob_q[scan_idx] <= loc_q[scan_unit][scan_idx];
            if (commit_end) begin
                for (int r = 0; r < NR; r++) begin
                    vt_q[r][scan_unit]   <= 1'b0;
                    mod_q[scan_unit][r]  <= 1'b0;
                    prod_q[scan_unit][r] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/mvrf_chk.sv
module mvrf_chk #(
    parameter int NU = 4,
    parameter int NR = 16,
    parameter int UW = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  busy,
    input logic                  done,
    input logic                  mismatch,
    input logic                  squash_req,
    input logic [UW-1:0]         squash_unit,
    input logic                  spawn_req,
    input logic [UW-1:0]         spawn_child,
    input logic [NR-1:0][NU-1:0] vt
);
    logic [UW-1:0] sq_q;
    logic          col_any;

    always_ff @(posedge clk) sq_q <= squash_unit;

    always_comb begin
        col_any = 1'b0;
        for (int r = 0; r < NR; r++) col_any = col_any | vt[r][sq_q];
    end

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_scan_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    assert_mismatch_only_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |-> done);

    assert_squash_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_req && !(spawn_req && spawn_child == squash_unit)) |=> !col_any);
endmodule

bind mvrf_top mvrf_chk #(.NU(NUM_UNITS), .NR(NUM_REGS), .UW(UW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .mismatch   (mismatch),
    .squash_req (squash_req),
    .squash_unit(squash_unit),
    .spawn_req  (spawn_req),
    .spawn_child(spawn_child),
    .vt         (vt_q)
);

// File: tb/tb_mvrf_top.sv
`timescale 1ns/1ps
module tb_mvrf_top;
    localparam int NU = 4, NR = 16, DW = 32, UW = 2, AW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NU*UW-1:0] thread_rank = '0;
    logic [NU-1:0]    in_slice = '0;
    logic [NU-1:0]    rd_en = '0;
    logic [NU*AW-1:0] rd_addr = '0;
    logic [NU*DW-1:0] rd_data;
    logic [NU-1:0]    wr_en = '0;
    logic [NU*AW-1:0] wr_addr = '0;
    logic [NU*DW-1:0] wr_data = '0;
    logic             spawn_req = 1'b0;
    logic [UW-1:0]    spawn_parent = '0, spawn_child = '0;
    logic [NR-1:0]    spawn_mask = '0;
    logic             squash_req = 1'b0;
    logic [UW-1:0]    squash_unit = '0;
    logic             val_req = 1'b0;
    logic [UW-1:0]    val_unit = '0;
    logic             commit_req = 1'b0;
    logic [UW-1:0]    commit_unit = '0;
    logic             busy, done, mismatch;

    int n_chk = 0;
    int n_bad = 0;

    mvrf_top dut (
        .clk(clk), .rst_n(rst_n), .thread_rank(thread_rank), .in_slice(in_slice),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .spawn_req(spawn_req), .spawn_parent(spawn_parent), .spawn_child(spawn_child),
        .spawn_mask(spawn_mask), .squash_req(squash_req), .squash_unit(squash_unit),
        .val_req(val_req), .val_unit(val_unit), .commit_req(commit_req),
        .commit_unit(commit_unit), .busy(busy), .done(done), .mismatch(mismatch)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        thread_rank = {2'd3, 2'd2, 2'd1, 2'd0};
        in_slice = '0;
    endtask

    task automatic set_ranks(input int r0, input int r1, input int r2, input int r3);
        thread_rank = {UW'(r3), UW'(r2), UW'(r1), UW'(r0)};
    endtask

    task automatic wr(input int u, input int a, input logic [31:0] d);
        wr_en[u] = 1'b1;
        wr_addr[u*AW +: AW] = AW'(a);
        wr_data[u*DW +: DW] = d;
        tick();
        wr_en[u] = 1'b0;
    endtask

    task automatic rd(input int u, input int a, input logic [31:0] exp, input string tag);
        rd_addr[u*AW +: AW] = AW'(a);
        rd_en[u] = 1'b1;
        #1;
        chk(tag, rd_data[u*DW +: DW], exp);
        tick();
        rd_en[u] = 1'b0;
    endtask

    task automatic run_seq(input bit is_val, input int u, output int cyc, output logic mis);
        if (is_val) begin val_req = 1'b1; val_unit = UW'(u); end
        else begin commit_req = 1'b1; commit_unit = UW'(u); end
        tick();
        val_req = 1'b0;
        commit_req = 1'b0;
        cyc = 0;
        while (!done && cyc < 64) begin
            tick();
            cyc++;
        end
        mis = mismatch;
        tick();
    endtask

    task automatic t_reset();
        do_reset();
        for (int u = 0; u < NU; u++) rd(u, 5, 32'h0, "R1 read after reset");
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 mismatch", 32'(mismatch), 0);
    endtask

    task automatic t_lookup();
        do_reset();
        wr(0, 3, 32'hA0);
        wr(1, 3, 32'hB1);
        wr(2, 4, 32'hC2);
        rd(0, 3, 32'hA0, "R2 own version u0");
        rd(1, 3, 32'hB1, "R2 own version u1");
        rd(3, 3, 32'hB1, "R3 nearest older holder");
        rd(2, 3, 32'hB1, "R3 nearest older holder u2");
        rd(0, 4, 32'h0, "R3 younger holder ignored");
        rd(3, 4, 32'hC2, "R3 older holder r4");
        rd(2, 5, 32'h0, "R3 committed fallback");
        set_ranks(0, 3, 2, 1);
        rd(3, 3, 32'hA0, "R3 rank change picks u0");
        rd(2, 3, 32'hA0, "R3 rank change u2");
    endtask

    task automatic t_spawn();
        do_reset();
        wr(2, 9, 32'h99);
        wr(1, 3, 32'hB1);
        wr(1, 6, 32'hD6);
        spawn_req = 1'b1; spawn_parent = 2'd1; spawn_child = 2'd2;
        spawn_mask = 16'h0008;
        tick();
        spawn_req = 1'b0;
        rd(2, 9, 32'h0, "R4 child old versions cleared");
        rd(2, 3, 32'hB1, "R4 masked copy");
        wr(1, 3, 32'hC3);
        rd(2, 3, 32'hB1, "R4 child keeps copied value");
        wr(1, 6, 32'hE6);
        rd(2, 6, 32'hE6, "R4 unmasked not copied");
    endtask

    task automatic t_validate();
        int c;
        logic m;
        do_reset();
        wr(0, 2, 32'd10);
        rd(1, 2, 32'd10, "R5 external read");
        run_seq(1'b1, 1, c, m);
        chk("R10 validate cycles", 32'(c), NR);
        chk("R6 validate pass", 32'(m), 0);
        wr(0, 2, 32'd11);
        rd(1, 2, 32'd11, "R5 second read");
        run_seq(1'b1, 1, c, m);
        chk("R6 stale live-in detected", 32'(m), 1);
    endtask

    task automatic t_slice();
        int c;
        logic m;
        do_reset();
        wr(0, 7, 32'd5);
        wr(0, 8, 32'd2);
        in_slice[1] = 1'b1;
        wr(1, 7, 32'd99);
        in_slice[1] = 1'b0;
        wr(1, 8, 32'd1);
        rd(1, 8, 32'd1, "R5 own body write read");
        run_seq(1'b1, 1, c, m);
        chk("R7 unread slice value ignored", 32'(m), 0);
        rd(1, 7, 32'd99, "R5 slice value read");
        run_seq(1'b1, 1, c, m);
        chk("R5 consumed slice value checked", 32'(m), 1);
        squash_req = 1'b1; squash_unit = 2'd1;
        tick();
        squash_req = 1'b0;
        run_seq(1'b1, 1, c, m);
        chk("R8 log cleared by squash", 32'(m), 0);
        rd(1, 7, 32'd5, "R8 versions cleared by squash");
    endtask

    task automatic t_commit();
        int c;
        logic m;
        do_reset();
        set_ranks(3, 1, 2, 0);
        wr(0, 1, 32'd7);
        rd(1, 1, 32'd0, "R3 committed before commit");
        val_req = 1'b1; val_unit = 2'd1;
        tick();
        val_req = 1'b0;
        tick();
        tick();
        commit_req = 1'b1; commit_unit = 2'd0;
        tick();
        commit_req = 1'b0;
        c = 0;
        while (!done && c < 64) begin tick(); c++; end
        tick();
        chk("R11 ignored request left no sequence", 32'(busy), 0);
        rd(1, 1, 32'd0, "R11 commit during scan ignored");
        run_seq(1'b0, 0, c, m);
        chk("R10 commit cycles", 32'(c), NR);
        rd(1, 1, 32'd7, "R9 modified register committed");
        rd(0, 1, 32'd7, "R9 column cleared, committed value");
        rd(1, 2, 32'd0, "R9 unmodified register unchanged");
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_lookup();
        t_spawn();
        t_validate();
        t_slice();
        t_commit();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule